// File: doc/BRIEF.md
# Cross-Scale Local Max Pooler

This block computes local-invariance responses from oriented filter outputs laid out as an image pyramid. For one orientation at a time it pairs each scale with the next coarser scale. It slides a square window over the finer grid and returns the signed maximum over every position in the window, taken from both scales of the pair. Orientations are never combined. The responses are read from an on-chip buffer through a simple read port that has one cycle of latency. Each pooled value leaves on a valid/ready stream that carries tags for its orientation and scale pair.

Software sets three values and then pulses `start`: the window size, the number of scales and the number of orientations. The block clamps these values and holds them for the whole run. It walks every orientation, then every scale pair, then every window. It pulses `done` after the last pooled value has been accepted. The data format is 32-bit signed fixed point: one sign bit, seven integer bits and 24 fraction bits. The maximum is a plain signed comparison.

Top module: `xscale_maxpool`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `out_valid` and `rd_en` are all low.
- R2: Scale `s` is a square grid of side max(BASE_DIM >> s, 1). A read address is {orientation, scale, y, x}, with x in the least significant field. Each field is as wide as its maximum count needs. Read data is taken one cycle after `rd_en`. Every read addresses a position inside its scale.
- R3: A pooled value is the signed maximum of two sets of responses. The first set is the fine-scale responses at every position of the window. The second set is the coarse-scale responses at (y >> 1, x >> 1) for each of those positions, which is the nearest-neighbour mapping onto the half-size grid. The maximum starts from the most negative value, so a window holding only 0x80000000 yields 0x80000000.
- R4: The window step is max(window >> 1, 1) in each axis. A window starts at each multiple of the step that lies inside the fine scale. It covers [start, min(start + window, side)) on each axis, so a window is clipped at the edge. Windows are emitted with x varying fastest.
- R5: A pooled value depends only on responses of its own orientation.
- R6: Orientation is the outer loop and scale pair the inner loop. Pair p combines scale p with scale p+1, so N scales give N-1 pairs per orientation. `out_ori` and `out_pair` tag each value.
- R7: `out_last` is high only on the final window of each orientation/pair plane.
- R8: While `out_valid` is high and `out_ready` is low, the value and all its tags stay unchanged.
- R9: The configuration is latched on a `start` accepted while idle. A `start` or a configuration change during a run, including one in the cycle of the final handshake, has no effect.
- R10: Configuration is clamped when latched: a window of 0 acts as 1, the scale count is clamped to [2, MAX_SCALES], and the orientation count is clamped to [1, MAX_ORI].
- R11: `done` is a one-cycle pulse in the cycle after the final handshake, and `busy` is low from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted only while idle) |
| cfg_win | input | WIN_W | Window side in positions |
| cfg_nscales | input | clog2(MAX_SCALES+1) | Number of pyramid scales |
| cfg_nori | input | clog2(MAX_ORI+1) | Number of orientations |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| rd_en | output | 1 | Buffer read strobe |
| rd_addr | output | OW+SW+2*DW | {orientation, scale, y, x} |
| rd_data | input | 32 | Response returned one cycle after `rd_en` |
| out_valid | output | 1 | Pooled value available |
| out_ready | input | 1 | Consumer accepts the value |
| out_data | output | 32 | Pooled signed maximum |
| out_last | output | 1 | Final value of the current plane |
| out_ori | output | OW | Orientation of the value |
| out_pair | output | SW | Scale pair (finer scale index) |

## Verification
Two events can land on the same clock edge. One is the final output handshake, which ends the run. The other is a new `start` carrying a different configuration, which must be dropped. The bench asserts `start` together with `out_ready` on the last pooled value. It then requires a single `done` pulse, `busy` low afterwards and no further reads or outputs. A second `start` is also injected early in a run with altered settings, and every later value must still match the originally latched configuration. Back-pressure from a periodic `out_ready` pattern overlaps the window boundaries, where the accumulator restarts in the same cycle as a handshake.

// File: rtl/xsp_pkg.sv
package xsp_pkg;
  localparam int VAL_W = 32;
  typedef logic signed [VAL_W-1:0] val_t;
  localparam val_t VAL_FLOOR = {1'b1, {(VAL_W-1){1'b0}}};

  typedef enum logic [2:0] {ST_IDLE, ST_RUN, ST_WAIT, ST_OUT, ST_FIN} state_t;

  // side of pyramid level lvl, never below one
  function automatic int unsigned level_dim(int unsigned base, int unsigned lvl);
    int unsigned d;
    d = (lvl >= 32) ? 0 : (base >> lvl);
    return (d == 0) ? 1 : d;
  endfunction

  // window advance for a given window side
  function automatic int unsigned stride_of(int unsigned w);
    return (w < 2) ? 1 : (w >> 1);
  endfunction

  function automatic int unsigned clip(int unsigned v, int unsigned lo, int unsigned hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // nearest-neighbour index on the half-size grid
  function automatic int unsigned coarse_of(int unsigned c);
    return c >> 1;
  endfunction

  function automatic val_t vmax(val_t a, val_t b);
    return (b > a) ? b : a;
  endfunction
endpackage

// File: rtl/xsp_cfg_latch.sv
module xsp_cfg_latch #(
  parameter int WIN_W      = 6,
  parameter int MAX_SCALES = 12,
  parameter int MAX_ORI    = 12,
  localparam int SCW = $clog2(MAX_SCALES + 1),
  localparam int OCW = $clog2(MAX_ORI + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIN_W-1:0] win_in,
  input  logic [SCW-1:0]   nsc_in,
  input  logic [OCW-1:0]   nori_in,
  output logic [WIN_W-1:0] win_q,
  output logic [SCW-1:0]   nsc_q,
  output logic [OCW-1:0]   nori_q
);
  import xsp_pkg::*;

  localparam int WIN_MAX = (1 << WIN_W) - 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q  <= WIN_W'(1);
      nsc_q  <= SCW'(2);
      nori_q <= OCW'(1);
    end else if (load) begin
      win_q  <= WIN_W'(clip(32'(win_in), 1, WIN_MAX));
      nsc_q  <= SCW'(clip(32'(nsc_in), 2, MAX_SCALES));
      nori_q <= OCW'(clip(32'(nori_in), 1, MAX_ORI));
    end
  end
endmodule

// File: rtl/xsp_walker.sv
module xsp_walker #(
  parameter int BASE_DIM   = 256,
  parameter int MAX_SCALES = 12,
  parameter int MAX_ORI    = 12,
  parameter int WIN_W      = 6,
  localparam int DW  = $clog2(BASE_DIM),
  localparam int SW  = $clog2(MAX_SCALES),
  localparam int OW  = $clog2(MAX_ORI),
  localparam int SCW = $clog2(MAX_SCALES + 1),
  localparam int OCW = $clog2(MAX_ORI + 1),
  localparam int CW  = ((DW > WIN_W) ? DW : WIN_W) + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             adv,
  input  logic [WIN_W-1:0] win,
  input  logic [SCW-1:0]   nsc,
  input  logic [OCW-1:0]   nori,
  output logic [OW-1:0]    ori,
  output logic [SW-1:0]    pair,
  output logic [SW-1:0]    rd_scale,
  output logic [DW-1:0]    rd_y,
  output logic [DW-1:0]    rd_x,
  output logic             last_read,
  output logic             last_win,
  output logic             last_all
);
  import xsp_pkg::*;

  logic [OW-1:0] ori_q;
  logic [SW-1:0] pair_q;
  logic [CW-1:0] wy, wx, py, px;
  logic          ph;   // 0: fine scale read, 1: coarse scale read

  logic [CW-1:0] side, step, win_c, ylim, xlim, yend, xend;
  logic          wrap_x, wrap_y, pair_end, ori_end;

  always_comb begin
    side     = CW'(level_dim(BASE_DIM, 32'(pair_q)));
    step     = CW'(stride_of(32'(win)));
    win_c    = CW'(win);
    ylim     = wy + win_c;
    xlim     = wx + win_c;
    yend     = (ylim > side) ? side - CW'(1) : ylim - CW'(1);
    xend     = (xlim > side) ? side - CW'(1) : xlim - CW'(1);
    wrap_x   = (wx + step) >= side;
    wrap_y   = (wy + step) >= side;
    pair_end = (32'(pair_q) + 2) == 32'(nsc);
    ori_end  = (32'(ori_q) + 1) == 32'(nori);
  end

  assign last_read = ph && (px == xend) && (py == yend);
  assign last_win  = last_read && wrap_x && wrap_y;
  assign last_all  = last_win && pair_end && ori_end;
  assign ori       = ori_q;
  assign pair      = pair_q;
  assign rd_scale  = ph ? pair_q + SW'(1) : pair_q;
  assign rd_y      = ph ? DW'(coarse_of(32'(py))) : DW'(py);
  assign rd_x      = ph ? DW'(coarse_of(32'(px))) : DW'(px);

  always_ff @(posedge clk) begin
    if (!rst_n || init) begin
      ori_q <= '0; pair_q <= '0;
      wy <= '0; wx <= '0; py <= '0; px <= '0; ph <= 1'b0;
    end else if (adv) begin
      if (!ph) begin
        ph <= 1'b1;
      end else begin
        ph <= 1'b0;
        if (px != xend) begin
          px <= px + CW'(1);
        end else if (py != yend) begin
          px <= wx;
          py <= py + CW'(1);
        end else if (!wrap_x) begin
          wx <= wx + step;
          px <= wx + step;
          py <= wy;
        end else if (!wrap_y) begin
          wx <= '0; px <= '0;
          wy <= wy + step;
          py <= wy + step;
        end else begin
          wx <= '0; px <= '0; wy <= '0; py <= '0;
          if (!pair_end) begin
            pair_q <= pair_q + SW'(1);
          end else begin
            pair_q <= '0;
            ori_q  <= ori_q + OW'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/xsp_maxacc.sv
module xsp_maxacc (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            din_valid,
  input  xsp_pkg::val_t   din,
  output xsp_pkg::val_t   acc
);
  import xsp_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) acc <= VAL_FLOOR;
    else if (din_valid)  acc <= vmax(acc, din);
  end
endmodule

// File: rtl/xscale_maxpool.sv
module xscale_maxpool #(
  parameter int BASE_DIM   = 256,
  parameter int MAX_SCALES = 12,
  parameter int MAX_ORI    = 12,
  parameter int WIN_W      = 6,
  localparam int DW  = $clog2(BASE_DIM),
  localparam int SW  = $clog2(MAX_SCALES),
  localparam int OW  = $clog2(MAX_ORI),
  localparam int SCW = $clog2(MAX_SCALES + 1),
  localparam int OCW = $clog2(MAX_ORI + 1),
  localparam int AW  = OW + SW + 2 * DW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [WIN_W-1:0]         cfg_win,
  input  logic [SCW-1:0]           cfg_nscales,
  input  logic [OCW-1:0]           cfg_nori,
  output logic                     busy,
  output logic                     done,
  output logic                     rd_en,
  output logic [AW-1:0]            rd_addr,
  input  logic [xsp_pkg::VAL_W-1:0] rd_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [xsp_pkg::VAL_W-1:0] out_data,
  output logic                     out_last,
  output logic [OW-1:0]            out_ori,
  output logic [SW-1:0]            out_pair
);
  import xsp_pkg::*;

  state_t state;

  // named internal events
  logic             accept_start, out_fire, win_close;
  logic [WIN_W-1:0] cfg_win_q;
  logic [SCW-1:0]   cfg_nsc_q;
  logic [OCW-1:0]   cfg_nori_q;
  logic [OW-1:0]    w_ori;
  logic [SW-1:0]    w_pair, w_scale;
  logic [DW-1:0]    w_y, w_x;
  logic             w_last_read, w_last_win, w_last_all;
  logic             data_due, tag_all;
  val_t             acc;

  assign accept_start = (state == ST_IDLE) && start;
  assign out_fire     = (state == ST_OUT) && out_ready;
  assign win_close    = (state == ST_RUN) && w_last_read;

  xsp_cfg_latch #(.WIN_W(WIN_W), .MAX_SCALES(MAX_SCALES), .MAX_ORI(MAX_ORI)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(accept_start),
    .win_in(cfg_win), .nsc_in(cfg_nscales), .nori_in(cfg_nori),
    .win_q(cfg_win_q), .nsc_q(cfg_nsc_q), .nori_q(cfg_nori_q)
  );

  xsp_walker #(.BASE_DIM(BASE_DIM), .MAX_SCALES(MAX_SCALES), .MAX_ORI(MAX_ORI),
               .WIN_W(WIN_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .init(accept_start), .adv(state == ST_RUN),
    .win(cfg_win_q), .nsc(cfg_nsc_q), .nori(cfg_nori_q),
    .ori(w_ori), .pair(w_pair), .rd_scale(w_scale), .rd_y(w_y), .rd_x(w_x),
    .last_read(w_last_read), .last_win(w_last_win), .last_all(w_last_all)
  );

  xsp_maxacc u_acc (
    .clk(clk), .rst_n(rst_n), .clear(accept_start || out_fire),
    .din_valid(data_due), .din(val_t'(rd_data)), .acc(acc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      data_due <= 1'b0;
      out_last <= 1'b0;
      tag_all  <= 1'b0;
      out_ori  <= '0;
      out_pair <= '0;
    end else begin
      data_due <= (state == ST_RUN);
      if (win_close) begin
        out_last <= w_last_win;
        tag_all  <= w_last_all;
        out_ori  <= w_ori;
        out_pair <= w_pair;
      end
      unique case (state)
        ST_IDLE: if (start) state <= ST_RUN;
        ST_RUN:  if (w_last_read) state <= ST_WAIT;
        ST_WAIT: state <= ST_OUT;
        ST_OUT:  if (out_ready) state <= tag_all ? ST_FIN : ST_RUN;
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FIN);
  assign rd_en     = (state == ST_RUN);
  assign rd_addr   = {w_ori, w_scale, w_y, w_x};
  assign out_valid = (state == ST_OUT);
  assign out_data  = acc;
endmodule

// File: rtl/xscale_maxpool_checker.sv
module xscale_maxpool_checker #(
  parameter int BASE_DIM   = 256,
  parameter int MAX_SCALES = 12,
  parameter int MAX_ORI    = 12,
  parameter int WIN_W      = 6,
  localparam int DW  = $clog2(BASE_DIM),
  localparam int SW  = $clog2(MAX_SCALES),
  localparam int OW  = $clog2(MAX_ORI),
  localparam int SCW = $clog2(MAX_SCALES + 1),
  localparam int OCW = $clog2(MAX_ORI + 1),
  localparam int AW  = OW + SW + 2 * DW
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      busy,
  input logic                      done,
  input logic                      rd_en,
  input logic [AW-1:0]             rd_addr,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [xsp_pkg::VAL_W-1:0] out_data,
  input logic                      out_last,
  input logic [OW-1:0]             out_ori,
  input logic [SW-1:0]             out_pair,
  input logic [WIN_W-1:0]          cfg_win_q,
  input logic [SCW-1:0]            cfg_nsc_q,
  input logic [OCW-1:0]            cfg_nori_q
);
  import xsp_pkg::*;

  logic [OW-1:0] a_ori;
  logic [SW-1:0] a_scale;
  logic [DW-1:0] a_y, a_x;
  assign {a_ori, a_scale, a_y, a_x} = rd_addr;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_en && !out_valid && !done)); // R1
  AST_ADDR_IN_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (32'(a_y) < level_dim(BASE_DIM, 32'(a_scale)) &&
               32'(a_x) < level_dim(BASE_DIM, 32'(a_scale)))); // R2
  AST_SCALE_IN_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> 32'(a_scale) < 32'(cfg_nsc_q)); // R6
  AST_ORI_IN_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> 32'(a_ori) < 32'(cfg_nori_q)); // R6
  AST_PAIR_IN_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(out_pair) + 2 <= 32'(cfg_nsc_q))); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last) &&
                                   $stable(out_ori) && $stable(out_pair))); // R8
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(cfg_win_q) && $stable(cfg_nsc_q) &&
                               $stable(cfg_nori_q))); // R9
  AST_WIN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cfg_win_q != '0 && 32'(cfg_nori_q) >= 1 && 32'(cfg_nori_q) <= MAX_ORI)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready && out_last)); // R11
endmodule

bind xscale_maxpool xscale_maxpool_checker #(
  .BASE_DIM(BASE_DIM), .MAX_SCALES(MAX_SCALES), .MAX_ORI(MAX_ORI), .WIN_W(WIN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rd_en(rd_en), .rd_addr(rd_addr),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
  .out_ori(out_ori), .out_pair(out_pair), .cfg_win_q(cfg_win_q), .cfg_nsc_q(cfg_nsc_q),
  .cfg_nori_q(cfg_nori_q)
);

// File: tb/xscale_maxpool_test.sv
module xscale_maxpool_test;
  localparam int BASE = 16;
  localparam int MS   = 4;
  localparam int MO   = 4;
  localparam int WW   = 6;
  localparam int DW   = 4;
  localparam int SW   = 2;
  localparam int OW   = 2;
  localparam int SCW  = 3;
  localparam int OCW  = 3;
  localparam int AW   = OW + SW + 2 * DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [WW-1:0]  cfg_win = '0;
  logic [SCW-1:0] cfg_nscales = '0;
  logic [OCW-1:0] cfg_nori = '0;
  logic busy, done, rd_en, out_valid, out_last;
  logic [AW-1:0] rd_addr;
  logic [31:0] rd_data = '0;
  logic out_ready = 1'b0;
  logic [31:0] out_data;
  logic [OW-1:0] out_ori;
  logic [SW-1:0] out_pair;

  int checks = 0, errors = 0, cyc = 0, cur_pat = 0;
  bit abort = 0, finished = 0, addr_bad = 0;

  always #2.5 clk = ~clk;

  xscale_maxpool #(.BASE_DIM(BASE), .MAX_SCALES(MS), .MAX_ORI(MO), .WIN_W(WW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_win(cfg_win), .cfg_nscales(cfg_nscales),
    .cfg_nori(cfg_nori), .busy(busy), .done(done), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_ori(out_ori), .out_pair(out_pair));

  function automatic int side_of(int s);
    int d = BASE >> s;
    return (d < 1) ? 1 : d;
  endfunction

  function automatic logic signed [31:0] resp(int o, int s, int y, int x, int pat);
    logic [31:0] h;
    if (pat == 1) return 32'sh80000000;
    if (pat == 2) return -(1000 + o * 100 + s * 10 + y + x);
    h = 32'(o) * 32'h9E3779B1 + 32'(s) * 32'h85EBCA77 + 32'(y) * 32'hC2B2AE3D
      + 32'(x) * 32'h27D4EB2F + 32'h01234567;
    h = h ^ (h >> 13);
    h = h * 32'h5BD1E995;
    h = h ^ (h >> 15);
    if (s == 1 && y == 0 && x == 0) h = 32'h80000000;
    if (s == 0 && y == 3 && x == 3) h = 32'h7FFFFFFF;
    return h;
  endfunction

  // buffer model: one cycle read latency (R2)
  always @(posedge clk) begin
    if (rd_en) begin
      int o, s, y, x;
      o = int'(rd_addr[AW-1 -: OW]);
      s = int'(rd_addr[2*DW +: SW]);
      y = int'(rd_addr[DW +: DW]);
      x = int'(rd_addr[0 +: DW]);
      if (y >= side_of(s) || x >= side_of(s)) addr_bad = 1;
      rd_data <= resp(o, s, y, x, cur_pat);
    end
  end

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic expect_out(input logic signed [31:0] ev, input bit el, input int eo,
                            input int ep, input bit stall, input bit inj_mid, input bit inj_end);
    int waited = 0;
    bit got = 0;
    if (abort) return;
    while (!got) begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      out_ready = stall ? ((cyc % 3) != 0) : 1'b1;
      if (inj_mid && waited == 0) begin
        start = 1'b1; cfg_win = 6'd10; cfg_nscales = 3'd2; cfg_nori = 3'd2;
      end
      if (out_valid) begin
        check(out_data === ev, "R3 R5 R8 pooled value", out_data, ev);
        check(out_last === el, "R7 last flag", 32'(out_last), 32'(el));
        check(32'(out_ori) == eo && 32'(out_pair) == ep, "R6 plane tags",
              {16'(out_ori), 16'(out_pair)}, {16'(eo), 16'(ep)});
        if (out_ready) begin
          got = 1;
          if (inj_end) start = 1'b1;   // R9: start in the final handshake cycle
        end
      end
      waited++;
      if (waited > 20000 && !got) begin
        check(0, "R11 output timeout", 0, 1);
        abort = 1;
        got = 1;
      end
    end
  endtask

  task automatic run(input int w, input int nsc, input int nori, input int pat,
                     input bit stall, input bit inject);
    int we, se, oe, st, total, idx;
    we = (w == 0) ? 1 : w;                       // R10
    se = (nsc < 2) ? 2 : ((nsc > MS) ? MS : nsc);
    oe = (nori == 0) ? 1 : ((nori > MO) ? MO : nori);
    st = (we / 2 < 1) ? 1 : we / 2;              // R4
    total = 0;
    for (int o = 0; o < oe; o++)
      for (int p = 0; p + 1 < se; p++)
        total += ((side_of(p) + st - 1) / st) * ((side_of(p) + st - 1) / st);
    cur_pat = pat;
    addr_bad = 0;
    @(negedge clk);
    cfg_win = WW'(w); cfg_nscales = SCW'(nsc); cfg_nori = OCW'(nori); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R9 busy after start", 32'(busy), 1);
    idx = 0;
    for (int o = 0; o < oe; o++) begin             // R6 orientation outer
      for (int p = 0; p + 1 < se; p++) begin
        int L = side_of(p);
        for (int wy = 0; wy < L; wy += st) begin
          for (int wx = 0; wx < L; wx += st) begin
            logic signed [31:0] m;
            bit lastw;
            m = 32'sh80000000;
            for (int y = wy; y < wy + we && y < L; y++)
              for (int x = wx; x < wx + we && x < L; x++) begin
                logic signed [31:0] a, b;
                a = resp(o, p, y, x, pat);
                b = resp(o, p + 1, y >> 1, x >> 1, pat);
                if (a > m) m = a;
                if (b > m) m = b;
              end
            lastw = (wy + st >= L) && (wx + st >= L);
            expect_out(m, lastw, o, p, stall, inject && idx == 1, inject && idx == total - 1);
            idx++;
          end
        end
      end
    end
    if (abort) return;
    @(negedge clk);
    start = 1'b0;
    check(done === 1'b1, "R11 done pulse", 32'(done), 1);
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R11 idle after done", {30'b0, done, busy}, 0);
    repeat (4) @(negedge clk);
    check(rd_en === 1'b0 && out_valid === 1'b0 && busy === 1'b0,
          "R9 late start ignored", {29'b0, rd_en, out_valid, busy}, 0);
    check(addr_bad == 0, "R2 read address inside scale", 32'(addr_bad), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && out_valid === 1'b0 && rd_en === 1'b0,
          "R1 reset state", {28'b0, busy, done, out_valid, rd_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && rd_en === 1'b0, "R1 idle after reset", {30'b0, busy, rd_en}, 0);
    run(10, 4, 4, 0, 1, 0);   // R3 R4 R5 R6 R7 R8 default window
    run(4, 3, 2, 1, 0, 0);    // R3 floor value only
    run(0, 7, 0, 0, 1, 1);    // R10 clamps, R9 mid-run and final-cycle start
    run(3, 2, 7, 2, 1, 0);    // R4 odd window, R10 orientation clamp, R5 negatives
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R11 watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule